// File: doc/BRIEF.md
# Dual-Reference Clock Supervisor

This block is the digital supervisor of a clock synthesizer. The synthesizer locks to one of two nominally 10 kHz reference inputs. The block runs on the 20.48 MHz local oscillator clock. It watches both asynchronous reference inputs and decides whether each one is alive. It then places the loop in one of three modes:

- `MODE_TRACK`: the selected reference is alive and no override is active. The phase detector is enabled.
- `MODE_NOREF`: the selected reference is dead but the other one is alive. The phase detector is gated off and the alarm is raised. The block never switches to the other reference on its own.
- `MODE_FREERUN`: both references are dead, or the force input is high. The phase detector is off, and the alarm and free-run status are high.

The mode register is re-evaluated on every clock, so each mode can be left for any other in one cycle. The transitions are:

- Any mode goes to `MODE_FREERUN` when `force_fr` is high or both qualifiers report a lost reference.
- Otherwise, any mode goes to `MODE_TRACK` when the qualifier of the selected input reports it alive.
- Otherwise, any mode goes to `MODE_NOREF`.
- `test_hiz` and reset both return the register to `MODE_FREERUN`.

The block also divides the oscillator clock by a parameterized ratio (2048 by default) to make a 10 kHz output. It provides a pad output-enable that board-level test logic uses to float the alarm, the free-run status and the divided output. Each reference passes through an edge-toggle capture, so pulses narrower than a clock period are not missed. Next comes a two-flop synchronizer and a change detector. Last is a qualifier that declares loss after 1.5 nominal periods without an edge and recovery after four timely edges.

Top module: `dual_ref_supervisor`

## Requirements
- R1: `ref_sel` = 0 selects input A and 1 selects input B. While the selected input is qualified alive and `force_fr` is low, `pd_enable` is 1 and `fr_status` is 0.
- R2: When the selected input is lost and the other is alive, `pd_enable` is 0, `alarm` is 1 and `fr_status` is 0. The block never moves to the other input by itself.
- R3: When the selected input is alive and the other input is missing, the loop keeps tracking (`pd_enable` = 1). `alarm` stays 0 while `pd_locked` is 1.
- R4: When both inputs are lost, `fr_status` = 1, `alarm` = 1 and `pd_enable` = 0.
- R5: While `force_fr` is 1, the block is in free run one clock later, whatever the reference state: `fr_status` = 1, `alarm` = 1, `pd_enable` = 0.
- R6: While `test_hiz` is 1, `pads_oe` is 0. The mode, the qualifiers and the divider are held in their reset state, so on release the block starts in free run with `div10k` = 0.
- R7: `alarm` is the OR of loss-of-reference and loss-of-lock. Loss-of-lock (`pd_locked` = 0) counts only in tracking mode, so in that mode `alarm` = NOT `pd_locked` within the same cycle.
- R8: `div10k` has a period of `DIV_RATIO` clocks with `DIV_RATIO`/2 clocks high. It is 0 out of reset.
- R9: A reference pulse shorter than one clock period still counts as a valid edge.
- R10: A reference is declared lost when no edge arrives for `DIV_RATIO`*3/2 clocks, and the mode and outputs follow within a few clocks. A gap shorter than that raises no alarm.
- R11: A lost reference becomes alive again only on the fourth consecutive edge, each arriving within the loss window. Three edges are not enough.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oscillator clock (20.48 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a | input | 1 | Reference input A, asynchronous |
| ref_b | input | 1 | Reference input B, asynchronous |
| ref_sel | input | 1 | Reference select: 0 = A, 1 = B |
| force_fr | input | 1 | Forces free-run mode when high |
| test_hiz | input | 1 | Test float/hold: clears the pad enable and holds state in reset |
| pd_locked | input | 1 | Lock status from the phase detector, 1 = locked |
| pd_enable | output | 1 | Phase detector enable |
| alarm | output | 1 | Alarm: loss of reference OR loss of lock |
| fr_status | output | 1 | High while in free run |
| div10k | output | 1 | Oscillator clock divided by `DIV_RATIO` |
| pads_oe | output | 1 | Output enable for alarm, fr_status and div10k pads |

## Verification
A qualifier stuck alive would keep `pd_enable` high and `alarm` low more than 1.5 reference periods after the input stopped. A qualifier that recovers too eagerly would clear `fr_status` after the third edge instead of the fourth. Both show up within a few clocks of the expected decision point. A mode register that picks the wrong input, or drifts to the other input, is visible at the ports two to three clocks after a change of `ref_sel` or of a reference state. A divider fault shows in the first measured period of `div10k`.

// File: rtl/ref_sup_pkg.sv
package ref_sup_pkg;

    typedef enum logic [1:0] {
        MODE_FREERUN = 2'd0,
        MODE_TRACK   = 2'd1,
        MODE_NOREF   = 2'd2
    } loop_mode_e;

    localparam int unsigned NUM_REFS = 2;

endpackage

// File: rtl/ref_qualifier.sv
module ref_qualifier #(
    parameter int unsigned TIMEOUT    = 3072,
    parameter int unsigned GOOD_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ref_in,
    output logic alive,
    output logic edge_p
);
    localparam int unsigned GW = $clog2(TIMEOUT + 1);
    localparam int unsigned EW = $clog2(GOOD_EDGES + 1);

    logic          tog;
    logic          s1, s2, s3;
    logic [GW-1:0] gap_cnt;
    logic [EW-1:0] good_cnt;

    // Edge capture in the reference domain: a narrow pulse flips the toggle
    always_ff @(posedge ref_in or negedge rst_n) begin
        if (!rst_n) tog <= 1'b0;
        else        tog <= ~tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= tog;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign edge_p = s2 ^ s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt  <= '0;
            good_cnt <= '0;
            alive    <= 1'b0;
        end else if (clr) begin
            gap_cnt  <= '0;
            good_cnt <= '0;
            alive    <= 1'b0;
        end else if (edge_p) begin
            gap_cnt <= '0;
            if (!alive) begin
                if (good_cnt == EW'(GOOD_EDGES - 1)) begin
                    alive    <= 1'b1;
                    good_cnt <= '0;
                end else begin
                    good_cnt <= good_cnt + 1'b1;
                end
            end
        end else if (gap_cnt != GW'(TIMEOUT)) begin
            gap_cnt <= gap_cnt + 1'b1;
            if (gap_cnt == GW'(TIMEOUT - 1)) begin
                alive    <= 1'b0;
                good_cnt <= '0;
            end
        end
    end

    assert_gap_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt <= GW'(TIMEOUT));
    assert_alive_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alive |-> (gap_cnt < GW'(TIMEOUT)));
    assert_rise_on_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alive) |-> $past(edge_p));
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import ref_sup_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold,
    input  logic [NUM_REFS-1:0] ref_alive,
    input  logic                ref_sel,
    input  logic                force_fr,
    input  logic                pd_locked,
    output logic                pd_enable,
    output logic                alarm,
    output logic                fr_status
);
    loop_mode_e mode_q, mode_d;

    always_comb begin
        if (force_fr || (ref_alive == '0))   mode_d = MODE_FREERUN;
        else if (ref_alive[ref_sel])          mode_d = MODE_TRACK;
        else                                  mode_d = MODE_NOREF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mode_q <= MODE_FREERUN;
        else if (hold) mode_q <= MODE_FREERUN;
        else           mode_q <= mode_d;
    end

    always_comb begin
        pd_enable = 1'b0;
        alarm     = 1'b1;
        fr_status = 1'b0;
        unique case (mode_q)
            MODE_FREERUN: begin
                fr_status = 1'b1;
            end
            MODE_TRACK: begin
                pd_enable = 1'b1;
                alarm     = ~pd_locked;
            end
            MODE_NOREF: begin
                alarm     = 1'b1;
            end
            default: begin
                fr_status = 1'b1;
            end
        endcase
    end

    assert_force_fr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        force_fr |=> fr_status);
    assert_fr_alarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fr_status |-> (alarm && !pd_enable));
    assert_quiet_alarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm |-> (pd_enable && pd_locked));
    assert_no_autoswitch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pd_enable |-> $past(ref_alive[ref_sel]));
endmodule

// File: rtl/clk_divider.sv
module clk_divider #(
    parameter int unsigned DIV = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic div_out
);
    localparam int unsigned CW   = $clog2(DIV);
    localparam int unsigned HALF = DIV / 2;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            div_out <= 1'b0;
        end else if (clr) begin
            cnt     <= '0;
            div_out <= 1'b0;
        end else begin
            if (cnt == CW'(HALF - 1)) begin
                cnt     <= '0;
                div_out <= ~div_out;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_div_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (cnt == CW'(HALF - 1)) |=> (div_out != $past(div_out)));
endmodule

// File: rtl/dual_ref_supervisor.sv
module dual_ref_supervisor
    import ref_sup_pkg::*;
#(
    parameter int unsigned DIV_RATIO  = 2048,
    parameter int unsigned GOOD_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_a,
    input  logic ref_b,
    input  logic ref_sel,
    input  logic force_fr,
    input  logic test_hiz,
    input  logic pd_locked,
    output logic pd_enable,
    output logic alarm,
    output logic fr_status,
    output logic div10k,
    output logic pads_oe
);
    localparam int unsigned TIMEOUT = (DIV_RATIO * 3) / 2;

    logic [NUM_REFS-1:0] refs_in;
    logic [NUM_REFS-1:0] ref_alive;
    logic [NUM_REFS-1:0] ref_edge;

    assign refs_in = {ref_b, ref_a};

    for (genvar g = 0; g < NUM_REFS; g++) begin : g_qual
        ref_qualifier #(
            .TIMEOUT    (TIMEOUT),
            .GOOD_EDGES (GOOD_EDGES)
        ) u_qual (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (test_hiz),
            .ref_in (refs_in[g]),
            .alive  (ref_alive[g]),
            .edge_p (ref_edge[g])
        );
    end

    mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (test_hiz),
        .ref_alive (ref_alive),
        .ref_sel   (ref_sel),
        .force_fr  (force_fr),
        .pd_locked (pd_locked),
        .pd_enable (pd_enable),
        .alarm     (alarm),
        .fr_status (fr_status)
    );

    clk_divider #(.DIV(DIV_RATIO)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (test_hiz),
        .div_out (div10k)
    );

    assign pads_oe = ~test_hiz;

    assert_hold_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        test_hiz |=> (fr_status && !div10k && (ref_alive == '0)));
endmodule

// File: tb/dual_ref_supervisor_test.sv
`timescale 1ns/1ps
module dual_ref_supervisor_test;
    localparam int DIV = 64;
    localparam int REF_NS = DIV * 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_sel = 1'b0, force_fr = 1'b0, test_hiz = 1'b0, pd_locked = 1'b1;
    logic gen_a = 1'b0, gen_b = 1'b0;
    logic ga_sig = 1'b0, gb_sig = 1'b0, man_a = 1'b0;
    logic ref_a, ref_b;
    logic pd_enable, alarm, fr_status, div10k, pads_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    assign ref_a = ga_sig | man_a;
    assign ref_b = gb_sig;

    always #5 clk = ~clk;

    dual_ref_supervisor #(.DIV_RATIO(DIV), .GOOD_EDGES(4)) uut (
        .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b),
        .ref_sel(ref_sel), .force_fr(force_fr), .test_hiz(test_hiz),
        .pd_locked(pd_locked), .pd_enable(pd_enable), .alarm(alarm),
        .fr_status(fr_status), .div10k(div10k), .pads_oe(pads_oe));

    // Reference generators: narrow pulses (R9), below one clock period
    initial begin
        int pw;
        #3;
        forever begin
            pw = 2 + int'($urandom % 8);
            if (gen_a) begin ga_sig = 1'b1; #(pw); ga_sig = 1'b0; #(REF_NS - pw); end
            else #(REF_NS);
        end
    end
    initial begin
        int pw;
        #211;
        forever begin
            pw = 2 + int'($urandom % 8);
            if (gen_b) begin gb_sig = 1'b1; #(pw); gb_sig = 1'b0; #(REF_NS - pw); end
            else #(REF_NS);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected {pd_enable, alarm, fr_status} from requirements R1-R5, R7 individually
    function automatic logic [2:0] exp_out(input bit a, input bit b, input bit sel,
                                           input bit frc, input bit lk);
        if (frc || (!a && !b)) return 3'b011;
        if ((sel ? b : a))     return {1'b1, ~lk, 1'b0};
        return 3'b010;
    endfunction

    task automatic chk_mode(input string req, input logic [2:0] e);
        chk(req, "pd_enable", pd_enable, e[2]);
        chk(req, "alarm", alarm, e[1]);
        chk(req, "fr_status", fr_status, e[0]);
    endtask

    task automatic man_pulse();
        man_a = 1'b1; #4; man_a = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int t_hi, per;
        void'($urandom(32'h5EED_2540));
        wait_cyc(5);
        rst_n = 1'b1;
        // Reset state
        chk("R6", "reset pads_oe", pads_oe, 1'b1);
        chk_mode("R4", 3'b011);
        chk("R8", "reset div10k", div10k, 1'b0);

        // R8: divider period and duty
        while (div10k !== 1'b1) @(negedge clk);
        t_hi = 0;
        while (div10k === 1'b1) begin t_hi++; @(negedge clk); end
        per = t_hi;
        while (div10k === 1'b0) begin per++; @(negedge clk); end
        chk_int("R8", "high time", t_hi, DIV / 2);
        chk_int("R8", "period", per, DIV);

        // R1/R3: both references alive, track A then B
        gen_a = 1'b1; gen_b = 1'b1; ref_sel = 1'b0; pd_locked = 1'b1;
        wait_cyc(450);
        chk_mode("R1", 3'b100);
        ref_sel = 1'b1; wait_cyc(3);
        chk_mode("R1", 3'b100);
        ref_sel = 1'b0; wait_cyc(3);

        // R7: loss of lock while tracking
        pd_locked = 1'b0; wait_cyc(1);
        chk("R7", "alarm on lock loss", alarm, 1'b1);
        chk("R7", "still tracking", pd_enable, 1'b1);
        pd_locked = 1'b1; wait_cyc(1);
        chk("R7", "alarm cleared", alarm, 1'b0);

        // R10: selected A stops; no alarm before window, alarm after it
        gen_a = 1'b0;
        wait_cyc(20);
        chk("R10", "alarm within gap", alarm, 1'b0);
        wait_cyc(110);
        chk_mode("R10", 3'b010);
        // R2: B still alive, no automatic switch
        wait_cyc(300);
        chk_mode("R2", 3'b010);
        // R7: lock input ignored outside tracking
        pd_locked = 1'b1; wait_cyc(2);
        chk("R7", "alarm in noref", alarm, 1'b1);
        ref_sel = 1'b1; wait_cyc(3);
        chk_mode("R1", 3'b100);

        // R4: both lost
        gen_b = 1'b0; wait_cyc(200);
        chk_mode("R4", 3'b011);

        // R11 and R9: manual narrow pulses on A
        ref_sel = 1'b0;
        for (int i = 0; i < 3; i++) begin man_pulse(); wait_cyc(DIV); end
        chk("R11", "three edges not enough", fr_status, 1'b1);
        man_pulse(); wait_cyc(8);
        chk("R11", "fourth edge requalifies", fr_status, 1'b0);
        chk("R3", "track A with B missing", pd_enable, 1'b1);
        chk("R3", "alarm low with B missing", alarm, 1'b0);
        gen_a = 1'b1; wait_cyc(100);

        // R5: force free run overrides live references
        gen_b = 1'b1; wait_cyc(400);
        force_fr = 1'b1; wait_cyc(2);
        chk_mode("R5", 3'b011);
        force_fr = 1'b0; wait_cyc(3);
        chk_mode("R1", 3'b100);

        // R6: test hold
        test_hiz = 1'b1; wait_cyc(5);
        chk("R6", "pads_oe off", pads_oe, 1'b0);
        test_hiz = 1'b0; @(negedge clk);
        chk("R6", "free run after release", fr_status, 1'b1);
        chk("R6", "divider restarted", div10k, 1'b0);
        chk("R6", "pads_oe on", pads_oe, 1'b1);
        wait_cyc(400);
        chk_mode("R6", 3'b100);

        // Constrained random mode sweep
        for (int it = 0; it < 40; it++) begin
            bit a, b, s, f, l;
            a = 1'($urandom); b = 1'($urandom); s = 1'($urandom);
            f = ($urandom % 5) == 0; l = ($urandom % 4) != 0;
            gen_a = a; gen_b = b; ref_sel = s; force_fr = f; pd_locked = l;
            wait_cyc(450);
            chk_mode("R2", exp_out(a, b, s, f, l));
        end

        finish_run();
    end
endmodule